// File: doc/BRIEF.md
# Idle Shutdown and Low-Charge Warning Supervisor

This block watches over the energy use of a small LED controller that runs from a battery. It counts how long the controller has been idle without a break, where idle means the controller reports its off mode and nobody is pressing the power-on button. When that idle time reaches about two minutes, the block drops a power-enable output. That output drives an electronic switch that disconnects the battery. Power comes back only through a dedicated power-on button. The button stands in for a mechanical supply switch.

The block also reads a 4-bit charge code from a level sensor. Code 0 stands for an empty cell and code 15 for a full one, on a linear scale. When the code is at or below a programmable threshold, a red LED blinks. The default threshold is code 12, which is about 80 %. The blink has a 50 % duty cycle and a period of two half-second ticks, so it runs at 1 Hz from a 50 MHz clock. Both the timeout and the tick divider are parameters, so short time scales can be used for checking.

Top module: `pwr_supervisor`

## Requirements
- R1: While `rst_n` is low, `pwr_en` is 1. When reset is released, every idle count restarts from zero and the blink phase is set to lit.
- R2: A clock edge is idle when `off_mode` is 1 and `pwr_on_btn` is 0. `pwr_en` falls at the TIMEOUT_TICKS×TICK_DIV-th consecutive idle rising edge, and not before.
- R3: A single non-idle edge, where `off_mode` is 0 or `pwr_on_btn` is 1, restarts the idle count from zero.
- R4: `pwr_on_btn` high at a rising edge makes `pwr_en` 1 after that edge. This takes priority over any expiry.
- R5: Once `pwr_en` is 0, it stays 0 until the button is pressed. `off_mode` going low does not restore it.
- R6: The warning condition is `batt_level` ≤ LOW_CODE, on the linear scale 0 = empty and 15 = full, with a default LOW_CODE of 12. With a higher code, `red_led` is 0.
- R7: When the warning becomes active with power on, `red_led` is 1 at once. It goes dark after TICK_DIV rising edges and then alternates every TICK_DIV edges.
- R8: `red_led` is 0 whenever `pwr_en` is 0. After power is restored, the blink starts again in the lit phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz nominal |
| rst_n | input | 1 | Asynchronous reset, active low |
| off_mode | input | 1 | High while the LED controller is in its off mode |
| pwr_on_btn | input | 1 | Power-on push button, already debounced, active high |
| batt_level | input | LEVEL_W | Charge code from the sensor vector |
| pwr_en | output | 1 | Enable for the battery switch |
| red_led | output | 1 | Low-charge warning LED |

## Verification
`pwr_en` is registered, so each check on it is made on the falling edge that follows the rising edge which should have changed it. For a timeout, that edge is exactly the TIMEOUT_TICKS×TICK_DIV-th idle edge counted from the last non-idle one. `red_led` is the product of registered state and the live level code. So a change of level is checked a moment after the input moves, and phase flips are checked TICK_DIV edges apart. During the random phase, a cycle model in the bench advances on every rising edge and is compared on each falling edge, before new stimulus is applied.

// File: rtl/pwr_sup_pkg.sv
package pwr_sup_pkg;

    typedef enum logic {
        PHASE_DARK = 1'b0,
        PHASE_LIT  = 1'b1
    } blink_phase_e;

    function automatic int unsigned cnt_width(input longint unsigned max_val);
        return (max_val > 1) ? $clog2(max_val + 1) : 1;
    endfunction

endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
    parameter int unsigned DIV = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int unsigned CW = pwr_sup_pkg::cnt_width(longint'(DIV) - 1);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     wrap;

    always_comb begin
        st_d = st_q;
        wrap = (st_q.cnt == LAST);
        if (clr || wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        tick = wrap && !clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pwr_idle_timer.sv
module pwr_idle_timer #(
    parameter int unsigned TICK_DIV      = 25_000_000,
    parameter int unsigned TIMEOUT_TICKS = 240
) (
    input  logic clk,
    input  logic rst_n,
    input  logic off_mode,
    input  logic pwr_on_btn,
    output logic pwr_en
);
    localparam int unsigned RW = pwr_sup_pkg::cnt_width(TIMEOUT_TICKS);
    localparam logic [RW-1:0] RELOAD = RW'(TIMEOUT_TICKS);

    typedef struct packed {
        logic [RW-1:0] remain;
        logic          pwr_en;
    } idle_st_t;

    idle_st_t st_d, st_q;
    logic     activity;
    logic     tick;
    logic     expire;

    assign activity = !off_mode || pwr_on_btn;

    pwr_tick_gen #(.DIV(TICK_DIV)) i_idle_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (activity),
        .tick (tick)
    );

    always_comb begin
        st_d   = st_q;
        expire = tick && (st_q.remain == RW'(1));
        if (activity) begin
            st_d.remain = RELOAD;
        end else if (tick && (st_q.remain != '0)) begin
            st_d.remain = st_q.remain - 1'b1;
        end
        if (pwr_on_btn) begin
            st_d.pwr_en = 1'b1;
        end else if (expire) begin
            st_d.pwr_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.remain <= RELOAD;
            st_q.pwr_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwr_en = st_q.pwr_en;
endmodule

// File: rtl/pwr_batt_flasher.sv
module pwr_batt_flasher #(
    parameter int unsigned TICK_DIV = 25_000_000,
    parameter int unsigned LEVEL_W  = 4,
    parameter int unsigned LOW_CODE = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_en,
    input  logic [LEVEL_W-1:0] batt_level,
    output logic               red_led
);
    import pwr_sup_pkg::*;

    localparam logic [LEVEL_W-1:0] THRESH = LEVEL_W'(LOW_CODE);

    typedef struct packed {
        blink_phase_e phase;
    } flash_st_t;

    flash_st_t st_d, st_q;
    logic      low_charge;
    logic      run;
    logic      tick;

    assign low_charge = (batt_level <= THRESH);
    assign run        = low_charge && pwr_en;

    pwr_tick_gen #(.DIV(TICK_DIV)) i_blink_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (!run),
        .tick (tick)
    );

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.phase = PHASE_LIT;
        end else if (tick) begin
            st_d.phase = (st_q.phase == PHASE_LIT) ? PHASE_DARK : PHASE_LIT;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PHASE_LIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign red_led = run && (st_q.phase == PHASE_LIT);
endmodule

// File: rtl/pwr_supervisor.sv
module pwr_supervisor #(
    parameter int unsigned TICK_DIV      = 25_000_000,
    parameter int unsigned TIMEOUT_TICKS = 240,
    parameter int unsigned LEVEL_W       = 4,
    parameter int unsigned LOW_CODE      = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               off_mode,
    input  logic               pwr_on_btn,
    input  logic [LEVEL_W-1:0] batt_level,
    output logic               pwr_en,
    output logic               red_led
);
    logic pwr_en_int;

    pwr_idle_timer #(
        .TICK_DIV     (TICK_DIV),
        .TIMEOUT_TICKS(TIMEOUT_TICKS)
    ) i_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .off_mode  (off_mode),
        .pwr_on_btn(pwr_on_btn),
        .pwr_en    (pwr_en_int)
    );

    pwr_batt_flasher #(
        .TICK_DIV(TICK_DIV),
        .LEVEL_W (LEVEL_W),
        .LOW_CODE(LOW_CODE)
    ) i_flash (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_en    (pwr_en_int),
        .batt_level(batt_level),
        .red_led   (red_led)
    );

    assign pwr_en = pwr_en_int;
endmodule

// File: rtl/pwr_supervisor_chk.sv
module pwr_supervisor_chk #(
    parameter int unsigned TICK_DIV      = 25_000_000,
    parameter int unsigned TIMEOUT_TICKS = 240,
    parameter int unsigned LEVEL_W       = 4,
    parameter int unsigned LOW_CODE      = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               off_mode,
    input logic               pwr_on_btn,
    input logic [LEVEL_W-1:0] batt_level,
    input logic               pwr_en,
    input logic               red_led
);
    localparam logic [63:0] LIMIT = 64'(TICK_DIV) * 64'(TIMEOUT_TICKS);

    logic [63:0] idle_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_run <= '0;
        end else if (!off_mode || pwr_on_btn) begin
            idle_run <= '0;
        end else if (idle_run != '1) begin
            idle_run <= idle_run + 64'd1;
        end
    end

    AST_FALL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> (idle_run == LIMIT)); // R2

    AST_ACTIVE_KEEPS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_en && !off_mode) |=> pwr_en); // R3

    AST_BTN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_on_btn |=> pwr_en); // R4

    AST_RISE_NEEDS_BTN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> $past(pwr_on_btn)); // R5

    AST_LED_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        red_led |-> (batt_level <= LEVEL_W'(LOW_CODE))); // R6

    AST_LED_NEEDS_PWR: assert property (@(posedge clk) disable iff (!rst_n)
        red_led |-> pwr_en); // R8
endmodule

bind pwr_supervisor pwr_supervisor_chk #(
    .TICK_DIV     (TICK_DIV),
    .TIMEOUT_TICKS(TIMEOUT_TICKS),
    .LEVEL_W      (LEVEL_W),
    .LOW_CODE     (LOW_CODE)
) i_pwr_supervisor_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .off_mode  (off_mode),
    .pwr_on_btn(pwr_on_btn),
    .batt_level(batt_level),
    .pwr_en    (pwr_en),
    .red_led   (red_led)
);

// File: tb/test_pwr_supervisor.sv
`timescale 1ns/1ps
module test_pwr_supervisor;
    localparam int D   = 4;
    localparam int T   = 6;
    localparam int TD  = D * T;
    localparam int LOW = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       off_mode = 1'b0;
    logic       pwr_on_btn = 1'b0;
    logic [3:0] batt_level = 4'd15;
    logic       pwr_en;
    logic       red_led;

    int n_cmp  = 0;
    int n_bad  = 0;
    int m_idle = 0;
    int m_fc   = 0;
    bit m_pwr  = 1'b1;

    always #2 clk = ~clk;

    pwr_supervisor #(
        .TICK_DIV(D), .TIMEOUT_TICKS(T), .LEVEL_W(4), .LOW_CODE(LOW)
    ) i_pwr_supervisor (
        .clk(clk), .rst_n(rst_n), .off_mode(off_mode), .pwr_on_btn(pwr_on_btn),
        .batt_level(batt_level), .pwr_en(pwr_en), .red_led(red_led)
    );

    // cycle model built from the requirements
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idle = 0; m_pwr = 1'b1; m_fc = 0;
        end else begin
            bit act, run;
            act = !off_mode || pwr_on_btn;
            run = m_pwr && (int'(batt_level) <= LOW);
            if (act) m_idle = 0;
            else if (m_idle < 1000000) m_idle = m_idle + 1;
            if (pwr_on_btn) m_pwr = 1'b1;
            else if (!act && m_idle == TD) m_pwr = 1'b0;
            m_fc = run ? m_fc + 1 : 0;
        end
    end

    function automatic bit exp_led();
        return m_pwr && (int'(batt_level) <= LOW) && (((m_fc / D) % 2) == 0);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        step(3);
        chk("R1 pwr_en in reset", pwr_en, 1);
        chk("R1 led in reset", red_led, 0);
        rst_n = 1'b1;
        step(1);

        // R2: exact timeout
        off_mode = 1'b1;
        step(TD - 1);
        chk("R2 before limit", pwr_en, 1);
        step(1);
        chk("R2 at limit", pwr_en, 0);

        // R5: off_mode low does not restore
        off_mode = 1'b0;
        step(3);
        chk("R5 stays off", pwr_en, 0);

        // R4: button restores even while idle
        off_mode = 1'b1; pwr_on_btn = 1'b1;
        step(1);
        chk("R4 button restore", pwr_en, 1);
        pwr_on_btn = 1'b0;

        // R3: one active edge restarts count
        step(TD - 2);
        off_mode = 1'b0; step(1); off_mode = 1'b1;
        step(TD - 1);
        chk("R3 restart before limit", pwr_en, 1);
        step(1);
        chk("R3 restart at limit", pwr_en, 0);
        pwr_on_btn = 1'b1; step(1); pwr_on_btn = 1'b0; off_mode = 1'b0;
        chk("R4 restore again", pwr_en, 1);

        // R6: threshold boundary
        batt_level = 4'd13; step(2);
        chk("R6 code 13 dark", red_led, 0);
        batt_level = 4'd12; #1;
        chk("R7 lit on entry", red_led, 1);
        step(D - 1);
        chk("R7 still lit", red_led, 1);
        step(1);
        chk("R7 dark phase", red_led, 0);
        step(D);
        chk("R7 lit again", red_led, 1);
        batt_level = 4'd0; #1;
        chk("R6 code 0 warns", red_led, 1);

        // R8: led forced off when power drops, restarts lit
        batt_level = 4'd5; off_mode = 1'b1;
        step(TD);
        chk("R8 pwr off", pwr_en, 0);
        chk("R8 led off", red_led, 0);
        pwr_on_btn = 1'b1; step(1); pwr_on_btn = 1'b0; off_mode = 1'b0;
        chk("R8 led lit after restore", red_led, 1);

        // random phase against the model
        for (int c = 0; c < 4000; c++) begin
            chk("R2 R3 R4 R5 model pwr_en", pwr_en, m_pwr);
            chk("R6 R7 R8 model red_led", red_led, exp_led());
            off_mode   = ($urandom % 8) != 0;
            pwr_on_btn = ($urandom % 48) == 0;
            if (($urandom % 16) == 0) batt_level = 4'($urandom % 16);
            #1;
            chk("R6 R7 R8 model red_led after change", red_led, exp_led());
            step(1);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule